// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Start and Polarity Control

This block generates four independent pulse-width modulated outputs from a single clock. Software programs each channel through a word-addressed register port. Each channel has a 32-bit cycle length and a 32-bit active-time length, both counted in clock ticks. Three shared bit registers, with one bit per channel, select inverted output, run each channel and drive its output-enable line.

A channel's settings are copied into its working counter only when its run bit goes from 0 to 1. Settings written while the channel runs are held until software clears the run bit and sets it again, so the cycle in progress is never disturbed. A stopped channel rests at the inactive level set by its polarity bit. A running channel whose loaded counts are both zero drives its output high (legacy stop level).

Top module: `pwm_quad_top`

## Requirements
- R1: Registers sit at byte addresses: active time of channel n at n*8, cycle length of channel n at n*8+4, polarity at 0x40, run at 0x44, output enable at 0xD0 (bit n of the last three belongs to channel n). A write is taken on a clock edge with `bus_wen` high. `bus_rdata` shows the last value written to the register at `bus_addr`, and 0 for any other address.
- R2: A synchronous reset clears every register and counter, so all `pwm_out` and `pwm_oe` bits read 0.
- R3: While a channel's run bit is 0, its output equals its polarity bit: low when the bit is 0 (normal), high when the bit is 1 (inverted).
- R4: If the run bit of a channel is written from 0 to 1 at clock edge E, the next edge loads the settings and starts tick k=0. With normal polarity, the output is then high on tick k when (k mod P) < H and low otherwise, where P is the loaded cycle length and H is the loaded active time.
- R5: With the polarity bit at 1, a running channel outputs the complement of the R4 waveform.
- R6: A loaded active time greater than or equal to the loaded nonzero cycle length gives a constant active level.
- R7: A loaded cycle length of zero with a nonzero active time holds a running channel at its inactive level.
- R8: When the loaded cycle length and active time are both zero, a running channel drives its output high whatever its polarity.
- R9: Settings written while a channel runs do not change its waveform. They take effect only after the run bit is cleared and set again.
- R10: Each `pwm_oe` bit follows the matching bit of the output-enable register.
- R11: Channels run independently; starting one channel does not alter another channel's waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wen | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pwm_out | output | 4 | PWM output of each channel |
| pwm_oe | output | 4 | Output-enable line of each channel |

## Verification
Readback and output-enable results are visible in the same cycle that follows the write edge. The bench samples them at the falling edge just after that write edge. A waveform starts one edge after the run bit is written. The bench therefore waits one more clock, calls that sample tick 0 and compares every later falling-edge sample with the value computed for that tick. For writes made while a channel runs, the bench checks that the old waveform keeps its period across many samples. It then restarts the channel and checks the new waveform with the same tick alignment.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;
    localparam int PWM_AW = 8;
    localparam logic [PWM_AW-1:0] POL_OFF = 8'h40;
    localparam logic [PWM_AW-1:0] RUN_OFF = 8'h44;
    localparam logic [PWM_AW-1:0] OE_OFF  = 8'hD0;

    function automatic logic [PWM_AW-1:0] act_off(input int ch);
        return PWM_AW'(ch * 8);
    endfunction

    function automatic logic [PWM_AW-1:0] len_off(input int ch);
        return PWM_AW'(ch * 8 + 4);
    endfunction
endpackage

// File: rtl/pwm_quad_regs.sv
module pwm_quad_regs
    import pwm_quad_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wen_i,
    input  logic [PWM_AW-1:0]        addr_i,
    input  logic [DW-1:0]            wdata_i,
    output logic [DW-1:0]            rdata_o,
    output logic [NCH-1:0][DW-1:0]   act_o,
    output logic [NCH-1:0][DW-1:0]   len_o,
    output logic [NCH-1:0]           pol_o,
    output logic [NCH-1:0]           run_o,
    output logic [NCH-1:0]           oe_o
);
    typedef struct packed {
        logic [NCH-1:0][DW-1:0] act;
        logic [NCH-1:0][DW-1:0] len;
        logic [NCH-1:0]         pol;
        logic [NCH-1:0]         run;
        logic [NCH-1:0]         oe;
    } reg_t;

    reg_t reg_d, reg_q;

    always_comb begin
        reg_d = reg_q;
        if (wen_i) begin
            for (int c = 0; c < NCH; c++) begin
                if (addr_i == act_off(c)) reg_d.act[c] = wdata_i;
                if (addr_i == len_off(c)) reg_d.len[c] = wdata_i;
            end
            if (addr_i == POL_OFF) reg_d.pol = wdata_i[NCH-1:0];
            if (addr_i == RUN_OFF) reg_d.run = wdata_i[NCH-1:0];
            if (addr_i == OE_OFF)  reg_d.oe  = wdata_i[NCH-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) reg_q <= '0;
        else     reg_q <= reg_d;
    end

    always_comb begin
        rdata_o = '0;
        for (int c = 0; c < NCH; c++) begin
            if (addr_i == act_off(c)) rdata_o = reg_q.act[c];
            if (addr_i == len_off(c)) rdata_o = reg_q.len[c];
        end
        if (addr_i == POL_OFF) rdata_o = DW'(reg_q.pol);
        if (addr_i == RUN_OFF) rdata_o = DW'(reg_q.run);
        if (addr_i == OE_OFF)  rdata_o = DW'(reg_q.oe);
    end

    assign act_o = reg_q.act;
    assign len_o = reg_q.len;
    assign pol_o = reg_q.pol;
    assign run_o = reg_q.run;
    assign oe_o  = reg_q.oe;

    // R1: a write to the run register shows up on the next cycle
    a_r1_run_write: assert property (@(posedge clk) disable iff (rst)
        (wen_i && addr_i == RUN_OFF) |=> (run_o == $past(wdata_i[NCH-1:0])));

    // R2: reset leaves every control bit cleared
    a_r2_reset_clear: assert property (@(posedge clk)
        rst |=> (run_o == '0 && oe_o == '0 && pol_o == '0));
endmodule

// File: rtl/pwm_quad_chan.sv
module pwm_quad_chan #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run_i,
    input  logic          pol_i,
    input  logic [DW-1:0] len_i,
    input  logic [DW-1:0] act_i,
    output logic          out_o
);
    typedef struct packed {
        logic [DW-1:0] cnt;
        logic [DW-1:0] len;
        logic [DW-1:0] act;
        logic          run;
    } ch_t;

    ch_t ch_d, ch_q;
    logic live;

    always_comb begin
        ch_d     = ch_q;
        ch_d.run = run_i;
        if (run_i && !ch_q.run) begin
            ch_d.len = len_i;
            ch_d.act = act_i;
            ch_d.cnt = '0;
        end else if (run_i) begin
            if (ch_q.len == '0 || ch_q.cnt >= ch_q.len - 1'b1) ch_d.cnt = '0;
            else                                                ch_d.cnt = ch_q.cnt + 1'b1;
        end else begin
            ch_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ch_q <= '0;
        else     ch_q <= ch_d;
    end

    assign live = run_i && ch_q.run;

    always_comb begin
        if (!live)                                  out_o = pol_i;
        else if (ch_q.len == '0 && ch_q.act == '0)  out_o = 1'b1;
        else if (ch_q.len == '0)                    out_o = pol_i;
        else                                        out_o = (ch_q.cnt < ch_q.act) ^ pol_i;
    end

    // R4: a rising run bit captures the programmed counts
    a_r4_load: assert property (@(posedge clk) disable iff (rst)
        (run_i && !ch_q.run) |=> (ch_q.len == $past(len_i) && ch_q.act == $past(act_i)));

    // R4: the tick counter stays inside the loaded cycle
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        (ch_q.len != '0) |-> (ch_q.cnt < ch_q.len));

    // R9: loaded counts never move while the channel keeps running
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (live && $past(live)) |-> ($stable(ch_q.len) && $stable(ch_q.act)));
endmodule

// File: rtl/pwm_quad_top.sv
module pwm_quad_top
    import pwm_quad_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wen,
    input  logic [PWM_AW-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic [NCH-1:0]    pwm_out,
    output logic [NCH-1:0]    pwm_oe
);
    logic [NCH-1:0][DW-1:0] act_w, len_w;
    logic [NCH-1:0]         pol_w, run_w;

    pwm_quad_regs #(.NCH(NCH), .DW(DW)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wen_i  (bus_wen),
        .addr_i (bus_addr),
        .wdata_i(bus_wdata),
        .rdata_o(bus_rdata),
        .act_o  (act_w),
        .len_o  (len_w),
        .pol_o  (pol_w),
        .run_o  (run_w),
        .oe_o   (pwm_oe)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        pwm_quad_chan #(.DW(DW)) u_chan (
            .clk  (clk),
            .rst  (rst),
            .run_i(run_w[g]),
            .pol_i(pol_w[g]),
            .len_i(len_w[g]),
            .act_i(act_w[g]),
            .out_o(pwm_out[g])
        );
    end
endmodule

// File: tb/tb_pwm_quad_top.sv
module tb_pwm_quad_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wen = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out, pwm_oe;

    int errors = 0;
    int checks = 0;
    logic [3:0] pol_sh = '0;
    logic [3:0] run_sh = '0;

    always #2.5 clk = ~clk;

    pwm_quad_top dut (
        .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_out(pwm_out), .pwm_oe(pwm_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    function automatic logic lvl(input int k, input int p, input int h, input logic pol);
        if (p == 0 && h == 0) return 1'b1;
        if (p == 0) return pol;
        return ((k % p) < h) ^ pol;
    endfunction

    task automatic set_run(input logic [3:0] m);
        run_sh = m;
        wr(8'h44, {28'd0, m});
    endtask

    task automatic t_reset;
        check("R2 out", {28'd0, pwm_out}, 32'd0);
        check("R2 oe", {28'd0, pwm_oe}, 32'd0);
        bus_addr = 8'h44; #1;
        check("R2 run reg", bus_rdata, 32'd0);
        bus_addr = 8'h0C; #1;
        check("R2 len1 reg", bus_rdata, 32'd0);
    endtask

    task automatic t_regs;
        wr(8'h10, 32'hDEAD_0001);
        wr(8'h1C, 32'h1234_5678);
        bus_addr = 8'h10; #1; check("R1 act2 readback", bus_rdata, 32'hDEAD_0001);
        bus_addr = 8'h1C; #1; check("R1 len3 readback", bus_rdata, 32'h1234_5678);
        bus_addr = 8'h80; #1; check("R1 unmapped read", bus_rdata, 32'd0);
        check("R1 idle after cfg", {28'd0, pwm_out}, 32'd0);
    endtask

    task automatic t_oe;
        wr(8'hD0, 32'h5);
        check("R10 oe 0101", {28'd0, pwm_oe}, 32'h5);
        bus_addr = 8'hD0; #1; check("R10 oe readback", bus_rdata, 32'h5);
        wr(8'hD0, 32'hA);
        check("R10 oe 1010", {28'd0, pwm_oe}, 32'hA);
    endtask

    task automatic t_idle;
        pol_sh = 4'b0110;
        wr(8'h40, {28'd0, pol_sh});
        check("R3 stopped level", {28'd0, pwm_out}, {28'd0, pol_sh});
    endtask

    // ch0 P5 H2 normal, ch1 P4 H1 inverted, started together (R4 R5 R11)
    task automatic t_wave;
        pol_sh = 4'b0010;
        wr(8'h40, {28'd0, pol_sh});
        wr(8'h00, 32'd2); wr(8'h04, 32'd5);
        wr(8'h08, 32'd1); wr(8'h0C, 32'd4);
        set_run(4'b0011);
        @(negedge clk);
        for (int k = 0; k < 12; k++) begin
            check("R4 ch0 wave", {31'd0, pwm_out[0]}, {31'd0, lvl(k, 5, 2, 1'b0)});
            check("R5 ch1 inverted", {31'd0, pwm_out[1]}, {31'd0, lvl(k, 4, 1, 1'b1)});
            @(negedge clk);
        end
    endtask

    // start ch2 while ch0 keeps running; ch0 phase must continue (R11, R6)
    task automatic t_indep;
        logic [31:0] s0 [0:19];
        wr(8'h10, 32'd7); wr(8'h14, 32'd3);
        set_run(4'b0111);
        @(negedge clk);
        for (int k = 0; k < 20; k++) begin
            s0[k] = {31'd0, pwm_out[0]};
            check("R6 ch2 constant active", {31'd0, pwm_out[2]}, 32'd1);
            @(negedge clk);
        end
        for (int k = 0; k < 15; k++)
            check("R11 ch0 periodic", s0[k], s0[k+5]);
    endtask

    // ch3: P0 H3 inactive (R7), then both zero high even inverted (R8)
    task automatic t_zero;
        wr(8'h18, 32'd3); wr(8'h1C, 32'd0);
        set_run(run_sh | 4'b1000);
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            check("R7 len zero inactive", {31'd0, pwm_out[3]}, 32'd0);
            @(negedge clk);
        end
        set_run(run_sh & 4'b0111);
        wr(8'h18, 32'd0);
        pol_sh = pol_sh | 4'b1000;
        wr(8'h40, {28'd0, pol_sh});
        check("R3 ch3 idle inverted", {31'd0, pwm_out[3]}, 32'd1);
        pol_sh = pol_sh & 4'b0111;
        wr(8'h40, {28'd0, pol_sh});
        check("R3 ch3 idle normal", {31'd0, pwm_out[3]}, 32'd0);
        set_run(run_sh | 4'b1000);
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            check("R8 both zero high", {31'd0, pwm_out[3]}, 32'd1);
            @(negedge clk);
        end
    endtask

    // new ch0 settings while running, then restart (R9)
    task automatic t_restart;
        logic [31:0] s0 [0:19];
        int highs;
        wr(8'h00, 32'd4); wr(8'h04, 32'd6);
        highs = 0;
        for (int k = 0; k < 20; k++) begin
            s0[k] = {31'd0, pwm_out[0]};
            highs += int'(pwm_out[0]);
            @(negedge clk);
        end
        for (int k = 0; k < 15; k++)
            check("R9 old period kept", s0[k], s0[k+5]);
        check("R9 old duty kept", highs, 32'd8);
        set_run(run_sh & 4'b1110);
        check("R3 ch0 stopped low", {31'd0, pwm_out[0]}, 32'd0);
        set_run(run_sh | 4'b0001);
        @(negedge clk);
        for (int k = 0; k < 12; k++) begin
            check("R9 new settings", {31'd0, pwm_out[0]}, {31'd0, lvl(k, 6, 4, 1'b0)});
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_oe();
        t_idle();
        t_wave();
        t_indep();
        t_zero();
        t_restart();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done (all requirements)");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule